// File: doc/BRIEF.md
# Staggered Multichannel PWM Bank

This block produces sixteen pulse-width-modulated outputs from one shared free-running 14-bit tick counter, so every output repeats with a period of 16384 clock cycles. Each output has a 14-bit high-time value. The output stays high for that many ticks, counted from a per-channel turn-on offset, and the window wraps across the end of the period when it has to. An input mode can be set per channel. In that mode a duty write carries an 8-bit brightness level, and the block expands it to a 14-bit high time along a power-law curve with exponent 2.2.

Turn-on offsets come from one global 5-bit stagger value whose least significant bit is worth 32 ticks. A channel with its stagger enabled starts at its own index times that step. A channel with its stagger disabled starts at the same tick as the channel below it, so groups of neighbouring outputs can switch together. Configuration comes in through a plain write port (address, data, strobe). Every setting that shapes the waveform is staged and takes effect only at the next period boundary, so no period ever carries a mix of old and new settings.

Top module: `pwm_stagger_bank`

## Requirements
- R1: The tick counter runs from 0 to 16383 and then wraps to 0, advancing by one per clock. While reset is held, and in the first period after it, every bit of `pwm_o` is 0.
- R2: A write to addresses 0 to 15 sets the staged high time of the channel with that index. In direct mode the value is `wr_data[13:0]`.
- R3: Bit n of the mode mask (address 18, `wr_data[15:0]`) selects brightness mode for channel n, and it applies to every duty write that follows. In that mode the staged high time becomes ceil(16383 × (b/255)^2.2), where b = `wr_data[7:0]`. So b=0 gives 0 and b=255 gives 16383.
- R4: A write to address 16 sets the staged stagger value from `wr_data[4:0]`. A write to address 17 sets the staged stagger-enable mask, where bit n belongs to channel n.
- R5: Channel 0 always starts at tick 0, whatever its enable bit holds. A channel n ≥ 1 with its enable bit set starts at (n × stagger × 32) mod 16384. With the bit clear, it starts at the same tick as channel n−1.
- R6: In the clock after the counter shows value c, `pwm_o[n]` is 1 exactly when (c − start_n) mod 16384 < high_n. Each channel is therefore high for high_n ticks per period, and the window wraps past tick 16383.
- R7: A high time of 0 keeps the output low for the whole period. A high time of 16383 keeps it low for exactly one tick per period.
- R8: Staged high times, the stagger value and the enable mask are copied to the active set when the counter passes from 16383 to 0. A write made part-way through a period does not change that period's waveform.
- R9: A write to any address from 19 to 31 changes no setting, staged or active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 5 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_o | output | 16 | PWM outputs, one per channel |

## Verification
A wrong tick count, offset or active high time shows directly as a shifted or resized pulse. A reference model that follows the outputs on every clock therefore catches it at the first tick where the bad window edge falls, and never later than one period (16384 cycles) after the configuration is committed. A fault in the staging path, such as a commit at the wrong moment or a write that leaks into the active set or into another channel, shows up in the period where the bad value first becomes active. This is confirmed by measuring the high time of each output over whole periods. A wrong brightness expansion shows only as a pulse width that is off by some ticks, which is why widths are counted exactly.

// File: rtl/pwm_stagger_pkg.sv
package pwm_stagger_pkg;

  // Wide enough for b^11 * out_max^5 with 8-bit input and 14-bit output.
  localparam int unsigned WIDE = 200;
  typedef logic [WIDE-1:0] wide_t;

  function automatic wide_t wpow(input wide_t base, input int unsigned e);
    wide_t acc;
    acc = WIDE'(1);
    for (int unsigned i = 0; i < e; i++) acc = acc * base;
    return acc;
  endfunction

  // Smallest y with y/out_max >= (v/in_max)^(11/5), i.e. a round-up expansion.
  function automatic int unsigned gamma_code(input int unsigned v,
                                             input int unsigned in_bits,
                                             input int unsigned out_bits);
    int unsigned in_max, out_max, lo, hi, mid;
    wide_t target, scale;
    in_max  = (32'd1 << in_bits) - 32'd1;
    out_max = (32'd1 << out_bits) - 32'd1;
    if (v == 0) return 0;
    target = wpow(WIDE'(v), 11) * wpow(WIDE'(out_max), 5);
    scale  = wpow(WIDE'(in_max), 11);
    lo = 0;
    hi = out_max;
    while (lo < hi) begin
      mid = (lo + hi) >> 1;
      if (wpow(WIDE'(mid), 5) * scale >= target) hi = mid;
      else lo = mid + 1;
    end
    return lo;
  endfunction

  // Turn-on tick of a channel whose own stagger bit is set, modulo the period.
  function automatic int unsigned stagger_offset(input int unsigned ch,
                                                 input int unsigned shift,
                                                 input int unsigned lsb,
                                                 input int unsigned cw);
    return ((ch * shift) << lsb) & ((32'd1 << cw) - 32'd1);
  endfunction

endpackage

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
  parameter int unsigned CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output logic          period_end
);
  localparam logic [CW-1:0] LAST = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + CW'(1);
  end

  assign period_end = (cnt == LAST);
endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_stagger_pkg::*;
#(
  parameter int unsigned NCH = 16,
  parameter int unsigned CW  = 14,
  parameter int unsigned SHW = 5,
  parameter int unsigned BW  = 8,
  parameter int unsigned AW  = 5,
  parameter int unsigned DW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              commit,
  output logic [NCH*CW-1:0] act_duty_flat,
  output logic [NCH*CW-1:0] stg_duty_flat,
  output logic [SHW-1:0]    act_shift,
  output logic [NCH-1:1]    act_en
);
  localparam int unsigned LUT_N      = 1 << BW;
  localparam logic [AW-1:0] A_SHIFT = AW'(NCH);
  localparam logic [AW-1:0] A_EN    = AW'(NCH + 1);
  localparam logic [AW-1:0] A_MODE  = AW'(NCH + 2);

  logic [CW-1:0]  lut [LUT_N];
  logic [SHW-1:0] stg_shift;
  logic [NCH-1:1] stg_en;
  logic [NCH-1:0] mode;

  // Brightness expansion table, fixed at elaboration.
  for (genvar v = 0; v < LUT_N; v++) begin : g_lut
    localparam logic [CW-1:0] CODE = CW'(gamma_code(v, BW, CW));
    assign lut[v] = CODE;
  end

  logic [CW-1:0] expanded;
  assign expanded = lut[wr_data[BW-1:0]];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          hit;
    logic [CW-1:0] code;
    logic [CW-1:0] stg_q;
    logic [CW-1:0] act_q;

    assign hit  = wr_en && (wr_addr == AW'(i));
    assign code = mode[i] ? expanded : wr_data[CW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stg_q <= '0;
      else if (hit) stg_q <= code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      act_q <= '0;
      else if (commit) act_q <= stg_q;
    end

    assign stg_duty_flat[i*CW +: CW] = stg_q;
    assign act_duty_flat[i*CW +: CW] = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_shift <= '0;
      stg_en    <= '0;
      mode      <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_SHIFT) stg_shift <= wr_data[SHW-1:0];
      if (wr_addr == A_EN)    stg_en    <= wr_data[NCH-1:1];
      if (wr_addr == A_MODE)  mode      <= wr_data[NCH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_shift <= '0;
      act_en    <= '0;
    end else if (commit) begin
      act_shift <= stg_shift;
      act_en    <= stg_en;
    end
  end
endmodule

// File: rtl/pwm_offset_chain.sv
module pwm_offset_chain
  import pwm_stagger_pkg::*;
#(
  parameter int unsigned NCH   = 16,
  parameter int unsigned CW    = 14,
  parameter int unsigned SHW   = 5,
  parameter int unsigned SHLSB = 5
) (
  input  logic [SHW-1:0]    shift,
  input  logic [NCH-1:1]    en,
  output logic [NCH*CW-1:0] off_flat
);
  logic [CW-1:0] off [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_off
    if (i == 0) begin : g_first
      assign off[i] = '0;
    end else begin : g_rest
      assign off[i] = en[i] ? CW'(stagger_offset(i, 32'(shift), SHLSB, CW))
                            : off[i-1];
    end
    assign off_flat[i*CW +: CW] = off[i];
  end
endmodule

// File: rtl/pwm_chan_out.sv
module pwm_chan_out #(
  parameter int unsigned CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] offset,
  input  logic [CW-1:0] duty,
  output logic          pwm
);
  logic [CW-1:0] since_on;
  assign since_on = cnt - offset;   // wraps modulo the period

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm <= 1'b0;
    else        pwm <= (since_on < duty);
  end
endmodule

// File: rtl/pwm_stagger_bank.sv
module pwm_stagger_bank
  import pwm_stagger_pkg::*;
#(
  parameter int unsigned NCH   = 16,
  parameter int unsigned CW    = 14,
  parameter int unsigned SHW   = 5,
  parameter int unsigned SHLSB = 5,
  parameter int unsigned BW    = 8,
  parameter int unsigned AW    = 5,
  parameter int unsigned DW    = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_o
);
  logic [CW-1:0]     cnt;
  logic              period_end;
  logic [NCH*CW-1:0] act_flat;
  logic [NCH*CW-1:0] stg_flat;
  logic [NCH*CW-1:0] off_flat;
  logic [SHW-1:0]    act_shift;
  logic [NCH-1:1]    act_en;
  logic [NCH-1:0]    zero_mask;

  pwm_period_cnt #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (cnt),
    .period_end (period_end)
  );

  pwm_cfg_regs #(
    .NCH(NCH), .CW(CW), .SHW(SHW), .BW(BW), .AW(AW), .DW(DW)
  ) u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .commit        (period_end),
    .act_duty_flat (act_flat),
    .stg_duty_flat (stg_flat),
    .act_shift     (act_shift),
    .act_en        (act_en)
  );

  pwm_offset_chain #(
    .NCH(NCH), .CW(CW), .SHW(SHW), .SHLSB(SHLSB)
  ) u_off (
    .shift    (act_shift),
    .en       (act_en),
    .off_flat (off_flat)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_out
    assign zero_mask[i] = (act_flat[i*CW +: CW] == '0);

    pwm_chan_out #(.CW(CW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt    (cnt),
      .offset (off_flat[i*CW +: CW]),
      .duty   (act_flat[i*CW +: CW]),
      .pwm    (pwm_o[i])
    );
  end
endmodule

// File: rtl/pwm_stagger_chk.sv
module pwm_stagger_chk #(
  parameter int unsigned NCH = 16,
  parameter int unsigned CW  = 14,
  parameter int unsigned AW  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [CW-1:0]     cnt,
  input logic              period_end,
  input logic [NCH-1:0]    zero_mask,
  input logic [NCH*CW-1:0] act_flat,
  input logic [NCH*CW-1:0] stg_flat,
  input logic [NCH-1:0]    pwm_o
);
  localparam logic [AW-1:0] FIRST_FREE = AW'(NCH + 3);

  // R1: counter advances by exactly one each clock, wrapping at the top
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cnt == CW'($past(cnt) + 1'b1)));

  // R7: a zero high time never lets the output rise
  p_zero_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pwm_o & $past(zero_mask)) == '0));

  // R5: channel 0 turns on at tick 0
  p_ch0_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !zero_mask[0]) |=> pwm_o[0]);

  // R8: active settings hold steady inside a period
  p_hold_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(act_flat));

  // R8: at the boundary the staged values become active
  p_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (act_flat == $past(stg_flat)));

  // R9: unused addresses leave staged values alone
  p_unused_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= FIRST_FREE) |=> $stable(stg_flat));
endmodule

bind pwm_stagger_bank pwm_stagger_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .cnt        (cnt),
  .period_end (period_end),
  .zero_mask  (zero_mask),
  .act_flat   (act_flat),
  .stg_flat   (stg_flat),
  .pwm_o      (pwm_o)
);

// File: tb/pwm_stagger_bank_tb.sv
module pwm_stagger_bank_tb;
  localparam int PER = 16384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] pwm_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit started = 0;

  // behavioural model state
  int mc;
  int act_d[16];
  int stg_d[16];
  int offs[16];
  int act_sh, stg_sh;
  bit [15:0] act_en, stg_en, mode_m;
  bit [15:0] exp_o;
  int widths[16];

  pwm_stagger_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_o(pwm_o)
  );

  always #2 clk = ~clk;

  function automatic int gam(int v);
    real r;
    if (v == 0) return 0;
    r = 16383.0 * $pow(v / 255.0, 2.2);
    return int'($ceil(r));
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mc = 0; act_sh = 0; stg_sh = 0; act_en = 0; stg_en = 0; mode_m = 0;
      exp_o = 0;
      for (int n = 0; n < 16; n++) begin act_d[n] = 0; stg_d[n] = 0; offs[n] = 0; end
    end else begin
      for (int n = 0; n < 16; n++)
        exp_o[n] = (((mc - offs[n] + PER) % PER) < act_d[n]);
      if (mc == PER - 1) begin
        act_sh = stg_sh; act_en = stg_en;
        for (int n = 0; n < 16; n++) act_d[n] = stg_d[n];
        offs[0] = 0;
        for (int n = 1; n < 16; n++)
          offs[n] = act_en[n] ? (n * act_sh * 32) % PER : offs[n-1];
      end
      if (wr_en) begin
        if (wr_addr < 16)
          stg_d[wr_addr] = mode_m[wr_addr] ? gam(wr_data[7:0]) : int'(wr_data[13:0]);
        else if (wr_addr == 16) stg_sh = wr_data[4:0];
        else if (wr_addr == 17) stg_en = wr_data;
        else if (wr_addr == 18) mode_m = wr_data;
      end
      mc = (mc + 1) % PER;
    end
    started = 1;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (pwm_o !== exp_o) begin
        errors++;
        $display("FAIL %s pwm_o=%h expected=%h at tick %0d", cur_req, pwm_o, exp_o, mc);
      end
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic to_period_start();
    do @(negedge clk); while (mc != 0);
  endtask

  task automatic measure();
    for (int n = 0; n < 16; n++) widths[n] = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      for (int n = 0; n < 16; n++) widths[n] += pwm_o[n];
    end
  endtask

  int e1[16];
  int e2[16];
  int e3[16];

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(pwm_o == 16'h0, "R1 reset", pwm_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(pwm_o == 16'h0, "R1 after reset", pwm_o, 0);

    // configuration 1: gamma on ch0..3, stagger 31, odd channels staggered
    cur_req = "R2 R3 R4 R5 R6 R7";
    wr(18, 16'h000F);
    wr(0, 0);   wr(1, 1);   wr(2, 128);  wr(3, 255);
    wr(4, 0);   wr(5, 16383); wr(6, 100); wr(7, 8000);
    wr(8, 12000); wr(9, 3000); wr(10, 500); wr(11, 16000);
    wr(12, 7);  wr(13, 1);  wr(14, 2000); wr(15, 8000);
    wr(16, 31);
    wr(17, 16'hAAAB);
    e1 = '{0, gam(1), gam(128), 16383, 0, 16383, 100, 8000,
           12000, 3000, 500, 16000, 7, 1, 2000, 8000};
    to_period_start();
    measure();
    for (int n = 0; n < 16; n++)
      check(widths[n] == e1[n], (n < 4) ? "R3 width" : "R6 R7 width", widths[n], e1[n]);
    check(gam(0) == 0 && e1[3] == 16383, "R3 end points", e1[3], 16383);

    // configuration 2 written mid-period: must not touch this period (R8)
    to_period_start();
    cur_req = "R8 R9";
    fork
      measure();
      begin
        repeat (4000) @(negedge clk);
        wr(18, 16'h0000);
        wr(0, 300);
        wr(4, 4000);
        wr(16, 5);
        wr(17, 16'hFFFF);
        wr(19, 16'hFFFF);  // R9 unused addresses
        wr(31, 16'h1234);
        wr(25, 16'h0000);
      end
    join
    for (int n = 0; n < 16; n++)
      check(widths[n] == e1[n], "R8 mid-period write", widths[n], e1[n]);

    cur_req = "R5 R6 R9";
    e2 = e1; e2[0] = 300; e2[4] = 4000;
    measure();
    for (int n = 0; n < 16; n++)
      check(widths[n] == e2[n], "R9 R2 width after commit", widths[n], e2[n]);

    // configuration 3: every stagger bit clear, brightness on channel 4
    cur_req = "R3 R5";
    wr(17, 16'h0000);
    wr(16, 7);
    wr(18, 16'h0010);
    wr(4, 200);
    e3 = e2; e3[4] = gam(200);
    to_period_start();
    measure();
    for (int n = 0; n < 16; n++)
      check(widths[n] == e3[n], "R3 R5 width", widths[n], e3[n]);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule